// File: doc/BRIEF.md
# Warp Issue Selector with Static Competition Limit

This block chooses, each clock cycle, which warp a shader core issues next from a fixed group of warp slots. It builds one total ordering of all slots. Live warps come first. A live warp is one that is supervised, has not exited and is not stalled waiting. Among live warps, the warp that issued most recently goes first, and the rest follow oldest first by their dynamic age id. Every slot that is not live goes after all live slots.

Only the first few entries of this ordering may compete for issue. The size of this window is the smaller of a programmable limit and the number of supervised slots. Inside the window, the earliest entry that is live and ready is granted, both as a one-hot vector and as an index. The full ordering and the window size are also output for observation. The most-recent-issue pointer moves only when the pipeline accepts a grant. It is placed on the lowest supervised slot when the roster of supervised warps is committed.

The limit and the policy code are loaded through a small configuration write. That write is honoured only while no grant is being offered. An illegal policy code or an oversized limit is refused and flagged.

Top module: `swl_issue_sched`

## Requirements
- R1: After reset the greedy pointer is empty, the limit equals the slot count (8), no grant is offered and `cfg_err` is low.
- R2: Live slots are ordered by ascending age id, compared as unsigned numbers. Equal ids are ordered by lower slot index first.
- R3: Slots that are unsupervised, exited or waiting are placed after every live slot, and among themselves they are ordered by ascending slot index. `cand_order` position p occupies bits [p*IDX_W +: IDX_W].
- R4: A grant that is accepted (`issue_accept` high while `grant_valid` is high) makes that slot take position 0 from the next cycle, for as long as it stays live.
- R5: The greedy pointer does not move on a grant that is not accepted, nor when no grant is offered.
- R6: A greedy slot that is waiting loses first position in the same cycle and regains it once no longer waiting. A greedy slot that has exited loses first position in the same cycle, and the pointer is cleared on the next edge.
- R7: `cand_count` equals min(limit, number of supervised slots).
- R8: The grant goes to the earliest ordering position below `cand_count` whose slot is live and ready. If there is none, `grant_valid` is 0, `grant_onehot` is 0 and `grant_idx` is 0.
- R9: A configuration write while idle is taken only with policy code 2'b00 (greedy-then-oldest) and a limit no larger than the slot count. Any other write leaves the limit unchanged and raises `cfg_err` for exactly the following cycle.
- R10: A configuration write in a cycle where `grant_valid` is high is dropped: the limit is kept and no error is raised.
- R11: `roster_commit` sets the greedy pointer to the lowest-index supervised slot, or clears it when no slot is supervised. It takes precedence over an accepted grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_valid | input | NUM_SLOTS | Slot holds a supervised warp |
| slot_exited | input | NUM_SLOTS | Warp in slot has exited |
| slot_waiting | input | NUM_SLOTS | Warp in slot is stalled waiting (e.g. barrier) |
| slot_ready | input | NUM_SLOTS | Warp has an instruction ready to issue |
| slot_age | input | NUM_SLOTS*AGE_W | Dynamic age id per slot, slot i at [i*AGE_W +: AGE_W] |
| issue_accept | input | 1 | Pipeline takes the offered grant this cycle |
| roster_commit | input | 1 | Supervised roster finalized; restart greedy pointer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_policy | input | 2 | Ordering policy code; only 2'b00 is legal |
| cfg_limit | input | CNT_W | Requested competition limit |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_onehot | output | NUM_SLOTS | One-hot grant |
| grant_idx | output | IDX_W | Index of granted slot |
| cand_order | output | NUM_SLOTS*IDX_W | Complete ordering of slots, position 0 in the low bits |
| cand_count | output | CNT_W | Number of leading positions allowed to compete |
| cfg_err | output | 1 | Previous-cycle configuration write was refused |

## Verification
Two events can land on the same edge: an accepted grant and a roster commit, both of which want to move the greedy pointer. The bench drives both in one cycle. It makes the accepted slot differ from the lowest supervised slot and gives that lowest slot the youngest age. The following cycle's grant and ordering then show which one won. A configuration write arriving together with a live grant is provoked the same way, and the window size seen in the next idle cycle shows that the write was dropped.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [1:0] {
    POL_GTO  = 2'b00,
    POL_RSV1 = 2'b01,
    POL_RSV2 = 2'b10,
    POL_RSV3 = 2'b11
  } swl_policy_e;
endpackage

// File: rtl/swl_rank.sv
// Pairwise ordering network: every slot counts how many slots precede it.
module swl_rank #(
  parameter int NUM_SLOTS = 8,
  parameter int AGE_W     = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_SLOTS-1:0]            live,
  input  logic [NUM_SLOTS-1:0]            greedy,
  input  logic [NUM_SLOTS-1:0][AGE_W-1:0] age,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] order
);
  // ahead[i][j] : slot j is placed before slot i
  logic [NUM_SLOTS-1:0] ahead [NUM_SLOTS];
  logic [NUM_SLOTS-1:0][IDX_W-1:0] rank;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
      if (i == j) begin : g_self
        assign ahead[i][j] = 1'b0;
      end else begin : g_pair
        localparam bit JLOW = (j < i);
        assign ahead[i][j] =
          (live[j] != live[i])     ? live[j] :
          (!live[i])               ? JLOW :
          (greedy[j] != greedy[i]) ? greedy[j] :
          (age[j] != age[i])       ? (age[j] < age[i]) :
                                     JLOW;
      end
    end
    assign rank[i] = IDX_W'($countones(ahead[i]));
  end

  always_comb begin
    order = '0;
    for (int p = 0; p < NUM_SLOTS; p++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (rank[s] == IDX_W'(p)) order[p] = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/swl_window_pick.sv
// Window sizing and first-ready selection over the ordering.
module swl_window_pick #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            valid,
  input  logic [NUM_SLOTS-1:0]            live,
  input  logic [NUM_SLOTS-1:0]            ready,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] order,
  input  logic [CNT_W-1:0]                limit,
  output logic [CNT_W-1:0]                count,
  output logic                            grant_valid,
  output logic [NUM_SLOTS-1:0]            grant_onehot,
  output logic [IDX_W-1:0]                grant_idx
);
  logic [CNT_W-1:0]     supervised;
  logic [NUM_SLOTS-1:0] elig_pos;

  assign supervised = CNT_W'($countones(valid));
  assign count      = (limit < supervised) ? limit : supervised;

  always_comb begin
    for (int p = 0; p < NUM_SLOTS; p++) begin
      elig_pos[p] = (CNT_W'(p) < count) && ready[order[p]] && live[order[p]];
    end
  end

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    for (int p = NUM_SLOTS - 1; p >= 0; p--) begin
      if (elig_pos[p]) begin
        grant_valid = 1'b1;
        grant_idx   = order[p];
      end
    end
    grant_onehot = grant_valid ? (NUM_SLOTS'(1) << grant_idx) : '0;
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= limit) && (count <= supervised));
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (|grant_onehot)));
endmodule

// File: rtl/swl_greedy.sv
// Most-recent-issue pointer.
module swl_greedy #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] valid,
  input  logic [NUM_SLOTS-1:0] exited,
  input  logic [NUM_SLOTS-1:0] live,
  input  logic                 accept,
  input  logic                 grant_valid,
  input  logic [IDX_W-1:0]     grant_idx,
  input  logic                 commit,
  output logic [NUM_SLOTS-1:0] greedy
);
  logic [IDX_W-1:0] ptr_q, ptr_d, first_sup;
  logic             vld_q, vld_d, upd;
  logic             took;

  assign took = accept && grant_valid;

  always_comb begin
    first_sup = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (valid[s]) first_sup = IDX_W'(s);
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    vld_d = vld_q;
    upd   = 1'b0;
    if (commit) begin
      upd   = 1'b1;
      ptr_d = first_sup;
      vld_d = |valid;
    end else if (took) begin
      upd   = 1'b1;
      ptr_d = grant_idx;
      vld_d = 1'b1;
    end else if (vld_q && exited[ptr_q]) begin
      upd   = 1'b1;
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else if (upd) begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
    end
  end

  assign greedy = vld_q ? (live & (NUM_SLOTS'(1) << ptr_q)) : '0;

  assert_hold_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !took && !(vld_q && exited[ptr_q])) |=> ($stable(ptr_q) && $stable(vld_q)));
  assert_take_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !commit) |=> (vld_q && ptr_q == $past(grant_idx)));
  assert_exit_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && exited[ptr_q] && !commit && !took) |=> !vld_q);
  assert_commit_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(|valid)) |=> !vld_q);
endmodule

// File: rtl/swl_cfg.sv
// Limit register with idle-only write and refusal flag.
module swl_cfg #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       policy,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             busy,
  output logic [CNT_W-1:0] limit_q,
  output logic             err_q
);
  import swl_pkg::*;

  logic             bad, take, err_d;
  logic [CNT_W-1:0] limit_d;

  always_comb begin
    bad     = (swl_policy_e'(policy) != POL_GTO) || (limit_in > CNT_W'(NUM_SLOTS));
    take    = we && !busy && !bad;
    err_d   = we && !busy && bad;
    limit_d = take ? limit_in : limit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= CNT_W'(NUM_SLOTS);
      err_q   <= 1'b0;
    end else begin
      if (take) limit_q <= limit_d;
      err_q <= err_d;
    end
  end

  assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !busy && bad) |=> (err_q && $stable(limit_q)));
  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy) |=> ($stable(limit_q) && !err_q));
  assert_limit_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q <= CNT_W'(NUM_SLOTS));
endmodule

// File: rtl/swl_issue_sched.sv
module swl_issue_sched #(
  parameter int NUM_SLOTS = 8,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_valid,
  input  logic [NUM_SLOTS-1:0]       slot_exited,
  input  logic [NUM_SLOTS-1:0]       slot_waiting,
  input  logic [NUM_SLOTS-1:0]       slot_ready,
  input  logic [NUM_SLOTS*AGE_W-1:0] slot_age,
  input  logic                       issue_accept,
  input  logic                       roster_commit,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_policy,
  input  logic [CNT_W-1:0]           cfg_limit,
  output logic                       grant_valid,
  output logic [NUM_SLOTS-1:0]       grant_onehot,
  output logic [IDX_W-1:0]           grant_idx,
  output logic [NUM_SLOTS*IDX_W-1:0] cand_order,
  output logic [CNT_W-1:0]           cand_count,
  output logic                       cfg_err
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NUM_SLOTS-1:0]            live, greedy;
  logic [NUM_SLOTS-1:0][AGE_W-1:0] age_w;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] order_w;
  logic [CNT_W-1:0]                limit_q;

  assign live  = slot_valid & ~slot_exited & ~slot_waiting;
  assign age_w = slot_age;

  swl_cfg #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .we(cfg_we), .policy(cfg_policy),
    .limit_in(cfg_limit), .busy(grant_valid), .limit_q(limit_q), .err_q(cfg_err)
  );

  swl_greedy #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_greedy (
    .clk(clk), .rst_n(rst_sync), .valid(slot_valid), .exited(slot_exited),
    .live(live), .accept(issue_accept), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .commit(roster_commit), .greedy(greedy)
  );

  swl_rank #(.NUM_SLOTS(NUM_SLOTS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_rank (
    .live(live), .greedy(greedy), .age(age_w), .order(order_w)
  );

  swl_window_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
    .clk(clk), .rst_n(rst_sync), .valid(slot_valid), .live(live),
    .ready(slot_ready), .order(order_w), .limit(limit_q), .count(cand_count),
    .grant_valid(grant_valid), .grant_onehot(grant_onehot), .grant_idx(grant_idx)
  );

  assign cand_order = order_w;

  assert_grant_live_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    grant_valid |-> (slot_ready[grant_idx] && live[grant_idx]));
  assert_greedy_head_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (|greedy) |-> greedy[order_w[0]]);
endmodule

// File: tb/tb_swl_issue_sched.sv
module tb_swl_issue_sched;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]   v, ex, wt, rd;
  logic [N*8-1:0] ag;
  logic           acc, com, we;
  logic [1:0]     pol;
  logic [3:0]     lim;
  logic           grant_valid, cfg_err;
  logic [N-1:0]   grant_onehot;
  logic [2:0]     grant_idx;
  logic [N*3-1:0] cand_order;
  logic [3:0]     cand_count;

  swl_issue_sched dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(v), .slot_exited(ex), .slot_waiting(wt),
    .slot_ready(rd), .slot_age(ag), .issue_accept(acc), .roster_commit(com),
    .cfg_we(we), .cfg_policy(pol), .cfg_limit(lim), .grant_valid(grant_valid),
    .grant_onehot(grant_onehot), .grant_idx(grant_idx), .cand_order(cand_order),
    .cand_count(cand_count), .cfg_err(cfg_err)
  );

  typedef struct {
    logic        gv;
    logic [2:0]  gi;
    logic [7:0]  oh;
    logic [3:0]  cnt;
    logic [23:0] ord;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  // reference model state
  logic [2:0] m_ptr = 0;
  logic       m_gv  = 0;
  logic [3:0] m_lim = 4'd8;
  logic       m_errp = 0;

  function automatic int key_of(int i);
    bit lv = v[i] && !ex[i] && !wt[i];
    bit g  = m_gv && (m_ptr == i) && lv;
    if (lv) return ((g ? 0 : 1) << 12) | (int'(ag[i*8 +: 8]) << 4) | i;
    return (1 << 16) | i;
  endfunction

  function automatic exp_t model(string tag);
    exp_t e;
    bit   used[N];
    int   ordv[N];
    int   sup = 0;
    for (int i = 0; i < N; i++) begin
      used[i] = 0;
      sup += v[i];
    end
    for (int p = 0; p < N; p++) begin
      int best = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (best < 0 || key_of(i) < key_of(best))) best = i;
      used[best] = 1;
      ordv[p] = best;
      e.ord[p*3 +: 3] = 3'(best);
    end
    e.cnt = (int'(m_lim) < sup) ? m_lim : 4'(sup);
    e.gv = 0; e.gi = 0; e.oh = 0;
    for (int p = 0; p < N; p++) begin
      int s = ordv[p];
      if (!e.gv && p < int'(e.cnt) && rd[s] && v[s] && !ex[s] && !wt[s]) begin
        e.gv = 1; e.gi = 3'(s); e.oh = 8'(1 << s);
      end
    end
    e.err = m_errp;
    e.tag = tag;
    return e;
  endfunction

  task automatic vec(input logic [7:0] vv, input logic [7:0] ee, input logic [7:0] ww,
                     input logic [7:0] rr, input logic [63:0] aa, input logic a_acc,
                     input logic a_com, input logic a_we, input logic [1:0] a_pol,
                     input logic [3:0] a_lim, input string tag);
    exp_t e;
    bit   bad;
    @(negedge clk);
    v = vv; ex = ee; wt = ww; rd = rr; ag = aa;
    acc = a_acc; com = a_com; we = a_we; pol = a_pol; lim = a_lim;
    e = model(tag);
    q.push_back(e);
    #5 -> chk_ev;
    @(posedge clk);
    bad = (a_pol != 2'b00) || (a_lim > 4'd8);
    m_errp = a_we && !e.gv && bad;
    if (a_we && !e.gv && !bad) m_lim = a_lim;
    if (a_com) begin
      m_gv = |vv;
      m_ptr = 0;
      for (int s = N - 1; s >= 0; s--) if (vv[s]) m_ptr = 3'(s);
    end else if (a_acc && e.gv) begin
      m_gv = 1; m_ptr = e.gi;
    end else if (m_gv && ee[m_ptr]) begin
      m_gv = 0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(chk_ev);
      e = q.pop_front();
      n_vec++;
      if (grant_valid !== e.gv || grant_idx !== e.gi || grant_onehot !== e.oh ||
          cand_count !== e.cnt || cand_order !== e.ord || cfg_err !== e.err) begin
        n_bad++;
        $display("FAIL %s: act gv=%0b idx=%0d oh=%b cnt=%0d ord=%h err=%0b exp gv=%0b idx=%0d oh=%b cnt=%0d ord=%h err=%0b",
                 e.tag, grant_valid, grant_idx, grant_onehot, cand_count, cand_order, cfg_err,
                 e.gv, e.gi, e.oh, e.cnt, e.ord, e.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // slot7..slot0 ages
  localparam logic [63:0] A1 = 64'h80_70_60_05_40_30_20_50;
  localparam logic [63:0] A2 = 64'h90_80_01_70_60_01_40_30;
  localparam logic [63:0] A3 = 64'hC0_C0_C0_C0_C0_C0_01_FF;
  localparam logic [63:0] A4 = 64'h30_20_10_F0_40_50_60_70;

  initial begin
    v = 0; ex = 0; wt = 0; rd = 0; ag = 0; acc = 0; com = 0; we = 0; pol = 0; lim = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    vec(8'h00, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R1 idle after reset");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R1 default limit");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R2 oldest granted");
    vec(8'hFF, 0, 0, 8'h40, A1, 0, 0, 0, 0, 0, "R5 grant not accepted");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R5 pointer unmoved");
    vec(8'hFF, 0, 0, 8'hFF, A2, 0, 0, 0, 0, 0, "R2 equal ages lower slot");
    vec(8'hFF, 0, 0, 8'hFF, A3, 0, 0, 0, 0, 0, "R2 unsigned compare");
    vec(8'hFF, 8'h10, 8'h02, 8'hFF, A1, 0, 0, 0, 0, 0, "R3 dead slots last");
    vec(8'h5F, 8'h10, 8'h02, 8'h12, A1, 0, 0, 0, 0, 0, "R8 dead ready not granted");
    vec(8'hFF, 0, 0, 8'h40, A1, 1, 0, 0, 0, 0, "R4 accept young slot");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R4 greedy first");
    vec(8'hFF, 0, 8'h40, 8'hFF, A1, 0, 0, 0, 0, 0, "R6 waiting greedy drops");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R6 waiting greedy resumes");
    vec(8'hFF, 8'h40, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R6 exited greedy drops");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 0, 0, 0, "R6 exited releases pointer");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 1, 2'b00, 4'd3, "R9 legal write");
    vec(8'hFF, 0, 0, 8'h08, A1, 0, 0, 0, 0, 0, "R8 ready outside window");
    vec(8'hFF, 0, 0, 8'h0C, A1, 0, 0, 0, 0, 0, "R7 window grant");
    vec(8'h03, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R7 fewer supervised");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 1, 2'b01, 4'd5, "R9 bad policy");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 1, 2'b00, 4'd9, "R9 error flag after policy");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R9 error flag after limit");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R9 error one cycle");
    vec(8'hFF, 0, 0, 8'hFF, A1, 0, 0, 1, 2'b00, 4'd8, "R10 write while busy");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 0, 0, 0, "R10 limit kept");
    vec(8'hF0, 0, 0, 8'h40, A4, 1, 1, 0, 0, 0, "R11 commit with accept");
    vec(8'hF0, 0, 0, 8'hF0, A4, 0, 0, 0, 0, 0, "R11 commit wins");
    vec(8'h00, 0, 0, 8'h00, A4, 0, 1, 0, 0, 0, "R11 commit empty roster");
    vec(8'hF0, 0, 0, 8'hF0, A4, 0, 0, 1, 2'b00, 4'd8, "R11 pointer cleared");
    vec(8'hFF, 0, 0, 8'h00, A1, 0, 0, 1, 2'b00, 4'd8, "R9 restore limit");

    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra;
      logic [7:0]  rex, rwt;
      for (int s = 0; s < N; s++)
        ra[s*8 +: 8] = ($urandom % 3 == 0) ? 8'($urandom % 4) : 8'($urandom);
      rex = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rwt = 8'($urandom) & 8'($urandom);
      vec(8'($urandom) | 8'h81, rex, rwt, 8'($urandom), ra, 1'($urandom),
          ($urandom % 16) == 0, ($urandom % 8) == 0,
          (($urandom % 4) == 0) ? 2'($urandom) : 2'b00, 4'($urandom % 10),
          "R2 R8 mixed traffic");
    end

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule